// File: doc/BRIEF.md
# Oversampling Serial Receiver with Sleep-Until-Wakeup

This block receives asynchronous serial frames on a single input line that rests high. A 13-bit modulus divider turns the system clock into a tick at sixteen times the bit rate. On each tick the receiver takes a sample of the synchronized line. Every bit (start, data and stop) is decided by a two-of-three vote over the samples in the middle of the bit. Frames carry eight or nine data bits, least significant bit first. The last of the nine data bits is delivered in the top position of the data word.

Software reads the received word and a set of status flags: data ready, overrun, noise, framing error and idle line. A single read strobe acknowledges all of them. One interrupt line combines the data and idle conditions under two enables. A sleep control lets a node ignore traffic that is not meant for it. While sleep is set, completed frames leave the data and the flags alone, and the interrupt is held off. Hardware clears the sleep bit on one of two wake events, chosen by a select input. The first is an idle line. The second is an address frame, which is a frame whose last data bit is one.

Top module: `uart_rx_wake`

## Requirements
- R1: While reset is high and on the first cycle after it, rdrf, overrun, noise, frame_err, idle, rwu and irq are all 0.
- R2: With baud_div = D > 0, a bit lasts 16·D clock cycles, and frames sent at that rate are received correctly. With baud_div = 0 the receiver is stopped, and a frame on rxd leaves rdrf at 0.
- R3: With nine_bit = 0, a frame is a low start bit, 8 data bits sent LSB first, and a high stop bit. Once the frame completes, rx_data[7:0] holds the data, rx_data[8] = 0, and rdrf = 1.
- R4: With nine_bit = 1, a frame carries 9 data bits, and the ninth bit received appears on rx_data[8].
- R5: Each bit value is the majority of the 7th, 8th and 9th of its 16 samples. A single disturbed sample does not change the value. A start bit whose majority is high is dropped as a false start, and no frame is reported.
- R6: noise is set in the same cycle as rdrf when the three samples of the start bit, of any data bit, or of the stop bit disagree. It stays 0 for clean frames.
- R7: A stop bit whose majority is low sets frame_err, together with rdrf.
- R8: When a frame completes while rdrf is 1 and no read is being made, overrun is set. rx_data, noise and frame_err keep the values of the earlier frame.
- R9: A data_rd pulse clears rdrf, overrun, noise, frame_err and idle on the next clock edge.
- R10: irq = !rwu & ((rx_irq_en & (rdrf | overrun)) | (idle_irq_en & idle)).
- R11: A rwu_set pulse sets rwu. While rwu is 1, a completed frame that does not wake the receiver changes neither rx_data nor any flag, the idle flag is not set, and irq is 0.
- R12: With wake_sel = 1, the line going idle does not clear rwu. A frame whose last data bit is 1 (bit 7 with 8 data bits, bit 8 with 9) clears rwu and is received normally.
- R13: With wake_sel = 0, detection of an idle line clears rwu and leaves the idle flag at 0.
- R14: Once the line has been active, idle is set after 16·(N+2) consecutive high samples, where N is the number of data bits. With idle_type = 0, high samples count from the end of the start bit. With idle_type = 1, counting starts only after the stop bit has been decided.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rxd | input | 1 | Serial input line, high when idle |
| baud_div | input | 13 | Modulus of the 16x tick divider, 0 stops the receiver |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| wake_sel | input | 1 | Wake event select: 0 idle line, 1 address frame |
| idle_type | input | 1 | Idle counting start: 0 after the start bit, 1 after the stop bit |
| rx_irq_en | input | 1 | Enables irq from data ready or overrun |
| idle_irq_en | input | 1 | Enables irq from the idle flag |
| rwu_set | input | 1 | Pulse that puts the receiver to sleep |
| data_rd | input | 1 | Read strobe that acknowledges data and flags |
| rx_data | output | 9 | Last received data word |
| rdrf | output | 1 | Received data ready |
| overrun | output | 1 | A frame was lost because rdrf was still set |
| noise | output | 1 | Samples of the delivered frame disagreed |
| frame_err | output | 1 | Stop bit of the delivered frame was low |
| idle | output | 1 | Idle line detected |
| rwu | output | 1 | Sleep state |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps every 8-bit data value and several 9-bit values. A wrong bit order or a misplaced ninth bit would therefore show up as a corrupted word. With a divider of one, the sample points fall on known clock cycles. This lets the bench flip exactly one sample of the start, a data or the stop bit, which must raise noise without changing the data, and then flip two samples, which must change the bit. A receiver that sampled off-centre, or that voted over the wrong samples, fails these checks. Further tests cover a false start and a low stop bit. An overrun frame with noise must leave the first frame's data and noise flag in place. The two idle-counting modes are told apart by checking at a moment between their thresholds. Both wake paths are checked, with the wrong wake event shown not to wake the receiver.

// File: rtl/urx_pkg.sv
package urx_pkg;

    localparam int URX_DMAX = 9;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [URX_DMAX-1:0] data;
        logic                last_bit;
        logic                noise;
        logic                ferr;
    } rx_frame_t;

    typedef struct packed {
        logic rdrf;
        logic ovr;
        logic noise;
        logic ferr;
        logic idle;
    } rx_flags_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic unan3(input logic a, input logic b, input logic c);
        return (a == b) && (b == c);
    endfunction

endpackage

// File: rtl/urx_baud.sv
module urx_baud #(
    parameter int DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (div == '0) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= div - ONE) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + ONE;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/urx_deframer.sv
module urx_deframer
    import urx_pkg::*;
#(
    parameter int OVS  = 16,
    parameter int SYNC = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      rxd,
    input  logic      nine,
    output logic      line,
    output logic      busy,
    output logic      done,
    output rx_frame_t frame
);
    localparam int SW = $clog2(OVS + 1);
    localparam int BW = $clog2(URX_DMAX + 1);
    localparam logic [SW-1:0] S_A   = SW'(OVS / 2 - 1);
    localparam logic [SW-1:0] S_B   = SW'(OVS / 2);
    localparam logic [SW-1:0] S_C   = SW'(OVS / 2 + 1);
    localparam logic [SW-1:0] S_END = SW'(OVS);

    logic [SYNC-1:0] sync_q;

    generate
        if (SYNC == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= rxd;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[SYNC-2:0], rxd};
            end
        end
    endgenerate

    assign line = sync_q[SYNC-1];

    rx_state_e           state;
    logic [SW-1:0]       scnt;
    logic [BW-1:0]       bidx;
    logic                s0, s1;
    logic                nacc;
    logic                fnine;
    logic [URX_DMAX-1:0] shreg;

    logic [SW-1:0] cur;
    logic          vote;
    logic          clean;
    logic [BW-1:0] last_idx;

    always_comb begin
        cur      = scnt + SW'(1);
        vote     = maj3(s0, s1, line);
        clean    = unan3(s0, s1, line);
        last_idx = fnine ? BW'(URX_DMAX - 1) : BW'(URX_DMAX - 2);
    end

    assign busy = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            scnt  <= '0;
            bidx  <= '0;
            s0    <= 1'b1;
            s1    <= 1'b1;
            nacc  <= 1'b0;
            fnine <= 1'b0;
            shreg <= '0;
            done  <= 1'b0;
            frame <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                if (state == ST_IDLE) begin
                    if (!line) begin
                        state <= ST_START;
                        scnt  <= SW'(1);
                        bidx  <= '0;
                        nacc  <= 1'b0;
                        shreg <= '0;
                        fnine <= nine;
                    end
                end else begin
                    if (cur == S_A) s0 <= line;
                    if (cur == S_B) s1 <= line;
                    if (cur == S_C) begin
                        case (state)
                            ST_START: begin
                                if (vote) state <= ST_IDLE;
                                else      nacc  <= !clean;
                            end
                            ST_DATA: begin
                                shreg[bidx] <= vote;
                                if (!clean) nacc <= 1'b1;
                            end
                            ST_STOP: begin
                                done           <= 1'b1;
                                frame.data     <= shreg;
                                frame.last_bit <= fnine ? shreg[URX_DMAX-1] : shreg[URX_DMAX-2];
                                frame.noise    <= nacc | !clean;
                                frame.ferr     <= !vote;
                                state          <= ST_IDLE;
                            end
                            default: state <= ST_IDLE;
                        endcase
                    end
                    if (cur == S_END) begin
                        scnt <= '0;
                        case (state)
                            ST_START: begin
                                state <= ST_DATA;
                                bidx  <= '0;
                            end
                            ST_DATA: begin
                                if (bidx == last_idx) state <= ST_STOP;
                                else                  bidx  <= bidx + BW'(1);
                            end
                            default: state <= ST_IDLE;
                        endcase
                    end else begin
                        scnt <= cur;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/urx_idle.sv
module urx_idle
    import urx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic line,
    input  logic busy,
    input  logic ilt,
    input  logic nine,
    output logic idle_evt
);
    localparam int CW = $clog2(OVS * (URX_DMAX + 2) + 1);
    localparam logic [CW-1:0] THR8 = CW'(OVS * (URX_DMAX + 1));
    localparam logic [CW-1:0] THR9 = CW'(OVS * (URX_DMAX + 2));

    logic [CW-1:0] cnt;
    logic          armed;
    logic [CW-1:0] thr;

    assign thr = nine ? THR9 : THR8;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            armed    <= 1'b0;
            idle_evt <= 1'b0;
        end else begin
            idle_evt <= 1'b0;
            if (busy) armed <= 1'b1;
            if (tick) begin
                if (!line || (ilt && busy)) begin
                    cnt <= '0;
                end else if (cnt < thr) begin
                    cnt <= cnt + CW'(1);
                    if ((cnt == thr - CW'(1)) && armed) begin
                        idle_evt <= 1'b1;
                        armed    <= 1'b0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/urx_flags.sv
module urx_flags
    import urx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                done,
    input  rx_frame_t           frame,
    input  logic                idle_evt,
    input  logic                data_rd,
    input  logic                rwu_set,
    input  logic                wake_sel,
    input  logic                rx_irq_en,
    input  logic                idle_irq_en,
    output logic [URX_DMAX-1:0] data,
    output rx_flags_t           flags,
    output logic                rwu,
    output logic                irq
);
    logic rdrf_live;
    logic addr_wake;
    logic take;

    always_comb begin
        rdrf_live = flags.rdrf && !data_rd;
        addr_wake = rwu && wake_sel && done && frame.last_bit;
        take      = done && (!rwu || addr_wake);
        irq       = !rwu && ((rx_irq_en && (flags.rdrf || flags.ovr)) ||
                             (idle_irq_en && flags.idle));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data  <= '0;
            flags <= '0;
            rwu   <= 1'b0;
        end else begin
            if (data_rd) flags <= '0;
            if (take) begin
                if (rdrf_live) begin
                    flags.ovr <= 1'b1;
                end else begin
                    flags.rdrf  <= 1'b1;
                    flags.noise <= frame.noise;
                    flags.ferr  <= frame.ferr;
                    data        <= frame.data;
                end
            end
            if (idle_evt && !rwu) flags.idle <= 1'b1;
            if (rwu_set)                           rwu <= 1'b1;
            else if (addr_wake)                    rwu <= 1'b0;
            else if (rwu && !wake_sel && idle_evt) rwu <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_rx_wake.sv
module uart_rx_wake
    import urx_pkg::*;
#(
    parameter int DIV_W = 13,
    parameter int OVS   = 16,
    parameter int SYNC  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rxd,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             nine_bit,
    input  logic             wake_sel,
    input  logic             idle_type,
    input  logic             rx_irq_en,
    input  logic             idle_irq_en,
    input  logic             rwu_set,
    input  logic             data_rd,
    output logic [8:0]       rx_data,
    output logic             rdrf,
    output logic             overrun,
    output logic             noise,
    output logic             frame_err,
    output logic             idle,
    output logic             rwu,
    output logic             irq
);
    logic      tick;
    logic      line;
    logic      busy;
    logic      done;
    logic      idle_evt;
    rx_frame_t frame;
    rx_flags_t flags;

    urx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk  (clk),
        .rst  (rst),
        .div  (baud_div),
        .tick (tick)
    );

    urx_deframer #(.OVS(OVS), .SYNC(SYNC)) u_deframe (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .rxd   (rxd),
        .nine  (nine_bit),
        .line  (line),
        .busy  (busy),
        .done  (done),
        .frame (frame)
    );

    urx_idle #(.OVS(OVS)) u_idle (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .line     (line),
        .busy     (busy),
        .ilt      (idle_type),
        .nine     (nine_bit),
        .idle_evt (idle_evt)
    );

    urx_flags u_flags (
        .clk         (clk),
        .rst         (rst),
        .done        (done),
        .frame       (frame),
        .idle_evt    (idle_evt),
        .data_rd     (data_rd),
        .rwu_set     (rwu_set),
        .wake_sel    (wake_sel),
        .rx_irq_en   (rx_irq_en),
        .idle_irq_en (idle_irq_en),
        .data        (rx_data),
        .flags       (flags),
        .rwu         (rwu),
        .irq         (irq)
    );

    assign rdrf      = flags.rdrf;
    assign overrun   = flags.ovr;
    assign noise     = flags.noise;
    assign frame_err = flags.ferr;
    assign idle      = flags.idle;
endmodule

// File: rtl/urx_chk.sv
module urx_chk (
    input logic       clk,
    input logic       rst,
    input logic [8:0] rx_data,
    input logic       rdrf,
    input logic       overrun,
    input logic       noise,
    input logic       frame_err,
    input logic       rwu,
    input logic       irq,
    input logic       wake_sel,
    input logic       data_rd
);
    // R6
    noise_with_ready_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(noise) |-> rdrf);

    // R7
    ferr_with_ready_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_err) |-> rdrf);

    // R8
    overrun_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> ($stable(rx_data) && $stable(noise) && $stable(frame_err)));

    // R9
    read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        data_rd |=> !overrun);

    // R11
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        rwu |-> !irq);

    // R12
    addr_wake_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(rwu) && $past(wake_sel)) |-> (rdrf || overrun));
endmodule

bind uart_rx_wake urx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_data   (rx_data),
    .rdrf      (rdrf),
    .overrun   (overrun),
    .noise     (noise),
    .frame_err (frame_err),
    .rwu       (rwu),
    .irq       (irq),
    .wake_sel  (wake_sel),
    .data_rd   (data_rd)
);

// File: tb/uart_rx_wake_tb.sv
module uart_rx_wake_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rxd = 1'b1;
    logic [12:0] baud_div = 13'd1;
    logic        nine_bit = 1'b0;
    logic        wake_sel = 1'b0;
    logic        idle_type = 1'b0;
    logic        rx_irq_en = 1'b0;
    logic        idle_irq_en = 1'b0;
    logic        rwu_set = 1'b0;
    logic        data_rd = 1'b0;
    logic [8:0]  rx_data;
    logic        rdrf, overrun, noise, frame_err, idle, rwu, irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    uart_rx_wake u_dut (
        .clk(clk), .rst(rst), .rxd(rxd), .baud_div(baud_div),
        .nine_bit(nine_bit), .wake_sel(wake_sel), .idle_type(idle_type),
        .rx_irq_en(rx_irq_en), .idle_irq_en(idle_irq_en),
        .rwu_set(rwu_set), .data_rd(data_rd),
        .rx_data(rx_data), .rdrf(rdrf), .overrun(overrun), .noise(noise),
        .frame_err(frame_err), .idle(idle), .rwu(rwu), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_rd();
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
    endtask

    task automatic pulse_sleep();
        rwu_set = 1'b1;
        @(negedge clk);
        rwu_set = 1'b0;
    endtask

    // one frame; gbit selects the bit (0 start, 1..N data, N+1 stop) whose
    // clock slots goff..goff+glen-1 are inverted
    task automatic send(input logic [8:0] d, input bit nine, input int cpb,
                        input int gbit, input int goff, input int glen);
        int nb;
        nb = nine ? 9 : 8;
        nine_bit = nine;
        for (int b = 0; b < nb + 2; b++) begin
            logic val;
            val = (b == 0) ? 1'b0 : ((b == nb + 1) ? 1'b1 : d[b-1]);
            for (int i = 0; i < cpb; i++) begin
                rxd = ((b == gbit) && (i >= goff) && (i < goff + glen)) ? ~val : val;
                @(negedge clk);
            end
        end
        rxd = 1'b1;
    endtask

    task automatic settle();
        wait_n(400);
        pulse_rd();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_n(4);
        // R1 reset state
        check("R1 rdrf", int'(rdrf), 0);
        check("R1 flags", int'({overrun, noise, frame_err, idle}), 0);
        check("R1 rwu/irq", int'({rwu, irq}), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", int'({rdrf, overrun, noise, frame_err, idle, rwu, irq}), 0);
        wait_n(20);

        // R3 exhaustive 8-bit sweep
        for (int v = 0; v < 256; v++) begin
            send(9'(v), 1'b0, 16, -1, 0, 0);
            check("R3 data", int'(rx_data), v);
            check("R3 ready", int'(rdrf), 1);
            check("R6 clean noise", int'({noise, frame_err}), 0);
            pulse_rd();
        end

        // R4 nine data bits
        begin
            logic [8:0] nv [4];
            nv[0] = 9'h100; nv[1] = 9'h0FF; nv[2] = 9'h1A5; nv[3] = 9'h055;
            for (int k = 0; k < 4; k++) begin
                send(nv[k], 1'b1, 16, -1, 0, 0);
                check("R4 data", int'(rx_data), int'(nv[k]));
                check("R4 ready", int'(rdrf), 1);
                pulse_rd();
            end
        end

        // R2 divider of 3
        baud_div = 13'd3;
        wait_n(10);
        send(9'h0A7, 1'b0, 48, -1, 0, 0);
        check("R2 div3 data", int'(rx_data), 'hA7);
        check("R2 div3 ready", int'(rdrf), 1);
        pulse_rd();
        send(9'h13C, 1'b1, 48, -1, 0, 0);
        check("R2 div3 nine data", int'(rx_data), 'h13C);
        pulse_rd();
        // R2 divider 0 stops the receiver
        baud_div = 13'd0;
        wait_n(10);
        send(9'h055, 1'b0, 16, -1, 0, 0);
        wait_n(40);
        check("R2 div0 no frame", int'(rdrf), 0);
        baud_div = 13'd1;
        wait_n(20);

        // R5 / R6 single sample disturbed: noise, data intact
        send(9'h05A, 1'b0, 16, 0, 7, 1);
        check("R6 start noise", int'(noise), 1);
        check("R5 start data", int'(rx_data), 'h5A);
        pulse_rd();
        send(9'h0C3, 1'b0, 16, 4, 7, 1);
        check("R6 data noise", int'(noise), 1);
        check("R5 data intact", int'(rx_data), 'hC3);
        pulse_rd();
        send(9'h081, 1'b0, 16, 9, 7, 1);
        check("R6 stop noise", int'(noise), 1);
        check("R7 stop ok", int'(frame_err), 0);
        check("R5 stop data", int'(rx_data), 'h81);
        pulse_rd();
        // R5 two samples disturbed flip the bit
        send(9'h000, 1'b0, 16, 1, 7, 2);
        check("R5 majority flip", int'(rx_data), 'h01);
        check("R6 flip noise", int'(noise), 1);
        pulse_rd();
        check("R9 noise cleared", int'(noise), 0);

        // R5 false start
        rxd = 1'b0;
        wait_n(6);
        rxd = 1'b1;
        wait_n(200);
        check("R5 false start", int'(rdrf), 0);
        settle();

        // R7 low stop bit
        send(9'h03C, 1'b0, 16, 9, 0, 12);
        wait_n(40);
        check("R7 frame error", int'(frame_err), 1);
        check("R7 ready", int'(rdrf), 1);
        check("R7 data", int'(rx_data), 'h3C);
        pulse_rd();
        check("R9 ferr cleared", int'(frame_err), 0);
        settle();

        // R8 overrun
        rx_irq_en = 1'b1;
        send(9'h011, 1'b0, 16, -1, 0, 0);
        check("R10 irq data", int'(irq), 1);
        send(9'h022, 1'b0, 16, 4, 7, 1);
        check("R8 overrun", int'(overrun), 1);
        check("R8 data kept", int'(rx_data), 'h11);
        check("R8 noise kept", int'(noise), 0);
        pulse_rd();
        check("R9 cleared", int'({rdrf, overrun}), 0);
        check("R10 irq off", int'(irq), 0);
        rx_irq_en = 1'b0;
        settle();

        // R14 idle_type 0, with idle interrupt
        idle_irq_en = 1'b1;
        idle_type = 1'b0;
        send(9'h0FF, 1'b0, 16, -1, 0, 0);
        wait_n(80);
        check("R14 ilt0 idle", int'(idle), 1);
        check("R10 irq idle", int'(irq), 1);
        pulse_rd();
        check("R9 idle cleared", int'(idle), 0);
        idle_irq_en = 1'b0;
        settle();
        // R14 idle_type 1 counts after the stop bit
        idle_type = 1'b1;
        send(9'h0FF, 1'b0, 16, -1, 0, 0);
        wait_n(80);
        check("R14 ilt1 not yet", int'(idle), 0);
        wait_n(160);
        check("R14 ilt1 idle", int'(idle), 1);
        idle_type = 1'b0;
        settle();

        // R12 address-mark wake
        wake_sel = 1'b1;
        rx_irq_en = 1'b1;
        pulse_sleep();
        check("R11 sleep set", int'(rwu), 1);
        send(9'h012, 1'b0, 16, -1, 0, 0);
        check("R11 frame ignored", int'(rdrf), 0);
        check("R11 data held", int'(rx_data), 'hFF);
        check("R11 irq held", int'(irq), 0);
        wait_n(400);
        check("R12 idle no wake", int'(rwu), 1);
        check("R11 idle flag held", int'(idle), 0);
        send(9'h085, 1'b0, 16, -1, 0, 0);
        check("R12 woke", int'(rwu), 0);
        check("R12 data", int'(rx_data), 'h85);
        check("R12 irq", int'(irq), 1);
        pulse_rd();
        pulse_sleep();
        send(9'h0FF, 1'b1, 16, -1, 0, 0);
        check("R12 nine bit7 no wake", int'(rwu), 1);
        send(9'h100, 1'b1, 16, -1, 0, 0);
        check("R12 nine woke", int'(rwu), 0);
        check("R12 nine data", int'(rx_data), 'h100);
        settle();

        // R13 idle-line wake
        wake_sel = 1'b0;
        pulse_sleep();
        send(9'h077, 1'b0, 16, -1, 0, 0);
        check("R11 asleep no ready", int'(rdrf), 0);
        check("R11 asleep irq", int'(irq), 0);
        check("R13 still asleep", int'(rwu), 1);
        wait_n(400);
        check("R13 idle woke", int'(rwu), 0);
        check("R13 idle flag", int'(idle), 0);
        send(9'h066, 1'b0, 16, -1, 0, 0);
        check("R13 next frame", int'(rx_data), 'h66);
        check("R10 irq after wake", int'(irq), 1);
        pulse_rd();

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule